// File: doc/BRIEF.md
# Sixteen-Point Twiddle Rotator Without Multipliers

This block multiplies a stream of complex samples by the twiddle factor W16^n = exp(-j2πn/16), one sample per clock. A 4-bit position count, supplied alongside each sample by the transform's sequencing logic, picks the exponent n through a fixed map. Only seven exponents are reachable: 0, 1, 2, 3, 4, 6 and 9. The block sits between two butterfly stages of a pipelined radix-2² transform.

The cosine and sine magnitudes are held as integers scaled by 256: 236, 98 and 181. Each product is built from shifted copies of the sample, summed in three-input adders. The ×181 product is derived from the ×98 product, so the two constants share adders. There is no coefficient memory and no general multiplier. Unit gain is treated as a coefficient of 256, and the -j case as a sine coefficient of 256. This lets every count value travel the same three-register path, so samples leave in the order they arrived.

Top module: `twr_rot16`

## Requirements
- R1: Count values 0, 4, 8, 12, 13, 14 and 15 select n=0. Both output parts then equal the input parts exactly.
- R2: Count 5 selects n=1 (cos 236, sin 98). Counts 1 and 6 select n=2 (cos 181, sin 181). Counts 7 and 9 select n=3 (cos 98, sin 236). All of these signs are positive.
- R3: Count 2 selects n=4, a multiply by -j. The real output equals the input imaginary part, and the imaginary output equals the negated input real part.
- R4: Counts 3 and 10 select n=6 (cos -181, sin +181). Count 11 selects n=9 (cos -236, sin -98).
- R5: With integer coefficients C and S, the pre-scaled results are P = a·C + b·S (real) and Q = b·C − a·S (imaginary), where a and b are the input real and imaginary parts. Each output is floor((P + 128) / 256), which is P/256 rounded to nearest with halves rounded up.
- R6: A result above 32767 is clamped to 32767, and a result below −32768 is clamped to −32768.
- R7: Every output appears exactly three clock edges after its input is sampled, whatever the count value. Back-to-back samples are accepted every cycle and leave in their arrival order.
- R8: The output valid signal equals the input valid signal delayed by three edges. Synchronous active-high reset clears the output valid signal and both output parts to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_cnt | input | 4 | Position count selecting the exponent |
| in_re | input | DATA_W | Input real part, signed |
| in_im | input | DATA_W | Input imaginary part, signed |
| out_vld | output | 1 | Output sample valid |
| out_re | output | DATA_W | Rotated real part, signed |
| out_im | output | DATA_W | Rotated imaginary part, signed |

## Verification
The bench drives every one of the sixteen count values. A wrong entry in the count map would therefore show up as a rotation by the wrong angle, a sign flip, or a swapped real and imaginary part. Full-scale negative inputs are sent on the -j and 3π/4 paths. There, a design without clamping would wrap to a large negative value instead of 32767. Small inputs probe the rounding: a truncating design would be off by one, and a missing bias would skew halves downward. A back-to-back stream with mixed counts exposes any count value that takes a different number of cycles, since it would reorder or misalign results. A mid-stream reset checks that in-flight valids are dropped.

// File: rtl/twr_pkg.sv
package twr_pkg;

    // coefficients are integers scaled by 2**COEF_FRAC
    localparam int COEF_FRAC = 8;

    typedef enum logic [2:0] {
        MAG_ZERO,
        MAG_98,
        MAG_181,
        MAG_236,
        MAG_UNIT
    } mag_e;

    typedef struct packed {
        mag_e cmag;
        mag_e smag;
        logic cneg;
        logic sneg;
    } rot_ctl_t;

    function automatic rot_ctl_t make_ctl(mag_e c, mag_e s, logic cn, logic sn);
        rot_ctl_t r;
        r.cmag = c;
        r.smag = s;
        r.cneg = cn;
        r.sneg = sn;
        return r;
    endfunction

    // position count -> rotation control
    function automatic rot_ctl_t decode_cnt(logic [3:0] cnt);
        case (cnt)
            4'd5:          return make_ctl(MAG_236,  MAG_98,   1'b0, 1'b0); // n=1
            4'd1, 4'd6:    return make_ctl(MAG_181,  MAG_181,  1'b0, 1'b0); // n=2
            4'd7, 4'd9:    return make_ctl(MAG_98,   MAG_236,  1'b0, 1'b0); // n=3
            4'd2:          return make_ctl(MAG_ZERO, MAG_UNIT, 1'b0, 1'b0); // n=4
            4'd3, 4'd10:   return make_ctl(MAG_181,  MAG_181,  1'b1, 1'b0); // n=6
            4'd11:         return make_ctl(MAG_236,  MAG_98,   1'b1, 1'b1); // n=9
            default:       return make_ctl(MAG_UNIT, MAG_ZERO, 1'b0, 1'b0); // n=0
        endcase
    endfunction

endpackage

// File: rtl/twr_angle_dec.sv
module twr_angle_dec
    import twr_pkg::*;
(
    input  logic [3:0] cnt,
    output rot_ctl_t   ctl
);
    always_comb ctl = decode_cnt(cnt);
endmodule

// File: rtl/twr_mcm.sv
// Shared constant multiplier for one operand: x*236 and x*98 are formed
// in one three-input adder each and registered; x*181 is derived after the
// register from the x*98 product.
module twr_mcm #(
    parameter int DATA_W = 16,
    parameter int PROD_W = 26
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [PROD_W-1:0] x_q,
    output logic signed [PROD_W-1:0] p98_q,
    output logic signed [PROD_W-1:0] p236_q,
    output logic signed [PROD_W-1:0] p181
);
    logic signed [PROD_W-1:0] xe;
    logic signed [PROD_W-1:0] p98_d;
    logic signed [PROD_W-1:0] p236_d;

    always_comb begin
        xe     = PROD_W'(x);
        p236_d = (xe <<< 8) - (xe <<< 4) - (xe <<< 2);
        p98_d  = (xe <<< 6) + (xe <<< 5) + (xe <<< 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            p98_q  <= '0;
            p236_q <= '0;
        end else begin
            x_q    <= xe;
            p98_q  <= p98_d;
            p236_q <= p236_d;
        end
    end

    // 181 = 2*98 - 16 + 1
    always_comb p181 = (p98_q <<< 1) - (x_q <<< 4) + x_q;
endmodule

// File: rtl/twr_round_sat.sv
module twr_round_sat #(
    parameter int DATA_W = 16,
    parameter int PROD_W = 26,
    parameter int FRAC   = 8
) (
    input  logic signed [PROD_W-1:0] acc,
    output logic signed [DATA_W-1:0] y
);
    localparam int SUM_W = PROD_W + 1;
    localparam int SH_W  = SUM_W - FRAC;
    localparam logic signed [SH_W-1:0] MAXV = SH_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [SH_W-1:0] MINV = -SH_W'(2 ** (DATA_W - 1));

    logic signed [SUM_W-1:0] biased;
    logic signed [SH_W-1:0]  shifted;

    always_comb begin
        biased  = SUM_W'(acc) + SUM_W'(2 ** (FRAC - 1));
        shifted = SH_W'(biased >>> FRAC);
        if (shifted > MAXV)      y = MAXV[DATA_W-1:0];
        else if (shifted < MINV) y = MINV[DATA_W-1:0];
        else                     y = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/twr_rot16.sv
module twr_rot16
    import twr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic [3:0]               in_cnt,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);
    localparam int PROD_W = DATA_W + COEF_FRAC + 2;
    localparam int LANES  = 2;   // lane 0 real, lane 1 imaginary

    // stage 1: products
    rot_ctl_t ctl_d, ctl_s1;
    logic     vld_s1;

    logic signed [DATA_W-1:0] lane_in [LANES];
    logic signed [PROD_W-1:0] x_q     [LANES];
    logic signed [PROD_W-1:0] p98_q   [LANES];
    logic signed [PROD_W-1:0] p236_q  [LANES];
    logic signed [PROD_W-1:0] p181    [LANES];

    assign lane_in[0] = in_re;
    assign lane_in[1] = in_im;

    twr_angle_dec u_dec (.cnt(in_cnt), .ctl(ctl_d));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        twr_mcm #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_mcm (
            .clk   (clk),
            .rst   (rst),
            .x     (lane_in[g]),
            .x_q   (x_q[g]),
            .p98_q (p98_q[g]),
            .p236_q(p236_q[g]),
            .p181  (p181[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_s1 <= make_ctl(MAG_ZERO, MAG_ZERO, 1'b0, 1'b0);
            vld_s1 <= 1'b0;
        end else begin
            ctl_s1 <= ctl_d;
            vld_s1 <= in_vld;
        end
    end

    // stage 2: coefficient select and complex combine
    function automatic logic signed [PROD_W-1:0] pick(
        mag_e m, logic neg,
        logic signed [PROD_W-1:0] x, logic signed [PROD_W-1:0] q98,
        logic signed [PROD_W-1:0] q181, logic signed [PROD_W-1:0] q236);
        logic signed [PROD_W-1:0] v;
        case (m)
            MAG_98:   v = q98;
            MAG_181:  v = q181;
            MAG_236:  v = q236;
            MAG_UNIT: v = x <<< COEF_FRAC;
            default:  v = '0;
        endcase
        return neg ? -v : v;
    endfunction

    logic signed [PROD_W-1:0] a_c, a_s, b_c, b_s;
    logic signed [PROD_W-1:0] sum_re_d, sum_im_d, sum_re_q, sum_im_q;
    logic                     vld_s2;

    always_comb begin
        a_c = pick(ctl_s1.cmag, ctl_s1.cneg, x_q[0], p98_q[0], p181[0], p236_q[0]);
        a_s = pick(ctl_s1.smag, ctl_s1.sneg, x_q[0], p98_q[0], p181[0], p236_q[0]);
        b_c = pick(ctl_s1.cmag, ctl_s1.cneg, x_q[1], p98_q[1], p181[1], p236_q[1]);
        b_s = pick(ctl_s1.smag, ctl_s1.sneg, x_q[1], p98_q[1], p181[1], p236_q[1]);
        sum_re_d = a_c + b_s;
        sum_im_d = b_c - a_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_re_q <= '0;
            sum_im_q <= '0;
            vld_s2   <= 1'b0;
        end else begin
            sum_re_q <= sum_re_d;
            sum_im_q <= sum_im_d;
            vld_s2   <= vld_s1;
        end
    end

    // stage 3: round, clamp, output register
    logic signed [DATA_W-1:0] re_d, im_d;

    twr_round_sat #(.DATA_W(DATA_W), .PROD_W(PROD_W), .FRAC(COEF_FRAC)) u_rs_re (
        .acc(sum_re_q), .y(re_d));
    twr_round_sat #(.DATA_W(DATA_W), .PROD_W(PROD_W), .FRAC(COEF_FRAC)) u_rs_im (
        .acc(sum_im_q), .y(im_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_re  <= '0;
            out_im  <= '0;
            out_vld <= 1'b0;
        end else begin
            out_re  <= re_d;
            out_im  <= im_d;
            out_vld <= vld_s2;
        end
    end
endmodule

// File: rtl/twr_rot16_chk.sv
module twr_rot16_chk #(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_vld,
    input logic [3:0]               in_cnt,
    input logic signed [DATA_W-1:0] in_re,
    input logic signed [DATA_W-1:0] in_im,
    input logic                     out_vld,
    input logic signed [DATA_W-1:0] out_re,
    input logic signed [DATA_W-1:0] out_im
);
    localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [1:0] since;
    always_ff @(posedge clk) begin
        if (rst)              since <= 2'd0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    // R8
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3) |-> (out_vld == $past(in_vld, 3)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && out_re == '0 && out_im == '0));

    // R1
    unit_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && $past(in_vld, 3) &&
         ($past(in_cnt, 3) >= 4'd12 || $past(in_cnt, 3) == 4'd0 ||
          $past(in_cnt, 3) == 4'd4  || $past(in_cnt, 3) == 4'd8))
        |-> (out_re == $past(in_re, 3) && out_im == $past(in_im, 3)));

    // R3
    minus_j_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && $past(in_vld, 3) && $past(in_cnt, 3) == 4'd2 &&
         $past(in_re, 3) != MOST_NEG)
        |-> (out_re == $past(in_im, 3) && DATA_W'(out_im + $past(in_re, 3)) == '0));
endmodule

bind twr_rot16 twr_rot16_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_cnt(in_cnt),
    .in_re(in_re), .in_im(in_im),
    .out_vld(out_vld), .out_re(out_re), .out_im(out_im));

// File: tb/tb_twr_rot16.sv
module tb_twr_rot16;
    localparam int DW = 16;
    localparam int NV = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_vld = 1'b0;
    logic [3:0]           in_cnt = '0;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic                 out_vld;
    logic signed [DW-1:0] out_re, out_im;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    twr_rot16 #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_cnt(in_cnt),
        .in_re(in_re), .in_im(in_im),
        .out_vld(out_vld), .out_re(out_re), .out_im(out_im));

    // {count, real, imag}
    localparam logic [35:0] VEC [NV] = '{
        36'h0_1234_ABCD, 36'h1_2000_1000, 36'h2_7FFF_8001, 36'h3_0400_FC00,
        36'h4_8000_7FFF, 36'h5_1000_F000, 36'h6_0001_0001, 36'h7_3000_0100,
        36'h8_FFFF_0001, 36'h9_0100_3000, 36'hA_F800_0800, 36'hB_1000_1000,
        36'hC_7FFF_8000, 36'hD_0055_FFAA, 36'hE_4321_8765, 36'hF_0000_0001
    };

    // requirement-level model: count -> cos/sin scaled by 256
    function automatic void coefs(input logic [3:0] c, output int cs, output int sn);
        case (c)
            4'd5:         begin cs =  236; sn =  98;  end
            4'd1, 4'd6:   begin cs =  181; sn =  181; end
            4'd7, 4'd9:   begin cs =   98; sn =  236; end
            4'd2:         begin cs =    0; sn =  256; end
            4'd3, 4'd10:  begin cs = -181; sn =  181; end
            4'd11:        begin cs = -236; sn = -98;  end
            default:      begin cs =  256; sn =    0; end
        endcase
    endfunction

    function automatic int rnd_sat(input longint p);
        longint q;
        q = (p + 128) >>> 8;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return int'(q);
    endfunction

    function automatic void model(input logic [3:0] c, input int a, input int b,
                                  output int er, output int ei);
        int cs, sn;
        coefs(c, cs, sn);
        er = rnd_sat(longint'(a) * cs + longint'(b) * sn);
        ei = rnd_sat(longint'(b) * cs - longint'(a) * sn);
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd5, 4'd1, 4'd6, 4'd7, 4'd9: return "R2";
            4'd2:                         return "R3";
            4'd3, 4'd10, 4'd11:           return "R4";
            default:                      return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    task automatic one(input string tag, input logic [3:0] c, input int a, input int b);
        int er, ei;
        model(c, a, b, er, ei);
        @(negedge clk);
        in_vld = 1'b1; in_cnt = c; in_re = DW'(a); in_im = DW'(b);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk(tag, int'(out_vld), 1, "valid");
        chk(tag, int'(out_re), er, $sformatf("real cnt=%0d", c));
        chk(tag, int'(out_im), ei, $sformatf("imag cnt=%0d", c));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int er_a [NV];
        int ei_a [NV];
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", int'(out_vld), 0, "reset valid");
        chk("R8", int'(out_re), 0, "reset real");
        chk("R8", int'(out_im), 0, "reset imag");
        rst = 1'b0;

        // table walk: every count value
        for (int i = 0; i < NV; i++)
            one(tag_of(VEC[i][35:32]), VEC[i][35:32],
                int'($signed(VEC[i][31:16])), int'($signed(VEC[i][15:0])));

        // R3 full-scale negative real: -a clamps
        one("R6", 4'd2, -32768, 5);
        // R6 n=6 with both parts full negative: imag 46336 clamps
        one("R6", 4'd3, -32768, -32768);
        // R6 n=1 positive full scale
        one("R6", 4'd5, 32767, 32767);
        // R5 rounding: 236 -> 1, -98 -> 0, halves up
        one("R5", 4'd5, 1, 0);
        one("R5", 4'd5, -1, 0);
        one("R5", 4'd1, 3, -3);
        one("R5", 4'd7, -5, 7);

        // R7 back-to-back stream with mixed counts, one result per cycle
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk("R7", int'(out_vld), 1, "stream valid");
                chk("R7", int'(out_re), er_a[i-3], $sformatf("stream real %0d", i-3));
                chk("R7", int'(out_im), ei_a[i-3], $sformatf("stream imag %0d", i-3));
            end
            if (i < NV) begin
                logic [3:0] c;
                c = 4'((i * 7) % 16);
                model(c, int'($signed(VEC[i][31:16])), int'($signed(VEC[i][15:0])),
                      er_a[i], ei_a[i]);
                in_vld = 1'b1; in_cnt = c;
                in_re = VEC[i][31:16]; in_im = VEC[i][15:0];
            end else begin
                in_vld = 1'b0;
            end
        end
        @(negedge clk);
        chk("R8", int'(out_vld), 0, "valid after stream");

        // R8 reset with samples in flight
        in_vld = 1'b1; in_cnt = 4'd5; in_re = 16'sd1000; in_im = 16'sd2000;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk("R8", int'(out_vld), 0, "in-flight dropped by reset");
        chk("R8", int'(out_re), 0, "real cleared by reset");
        repeat (3) @(negedge clk);
        chk("R8", int'(out_vld), 0, "no valid after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule